// File: doc/BRIEF.md
# Three-Byte Instruction Fetch Sequencer

This block is the front end of a small accumulator processor. It fetches one memory-reference instruction from a byte-wide memory with a 16-bit address and then loads that instruction's operand. The instruction takes three consecutive bytes: an opcode, then the high byte of an operand address, then its low byte. The sequencer steps through eight timing states. Even states copy an address into the address register. Odd states each issue one memory read and capture the byte on the next cycle.

A controller waits in the idle state T0 until `start` is sampled high. It then makes four reads in order: the opcode into the instruction register, the two address bytes into the temporary register (high half first), and finally the operand at the assembled address into the data register. A one-cycle `done` pulse marks the end. The program counter is left on the byte that follows the instruction, so the next `start` fetches the next instruction. An observation port shows the timing state and every architectural register, so that the surrounding datapath and the verification code can follow the sequence.

Top module: `opfetch_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the timing state becomes 0 (T0), the program counter becomes the parameter RESET_PC (default 0x0000), AR, TR, IR and DR become zero, and `done` and `mem_rd` are low.
- R2: In T0 with `start` low, the block issues no read and no register changes.
- R3: A fetch presents exactly four reads, each a single-cycle `mem_rd` pulse, at these addresses in order: P, P+1, P+2, then the assembled 16-bit address. Here P is the program counter when `start` was sampled.
- R4: IR receives the byte at P. TR bits 15:8 receive the byte at P+1 and TR bits 7:0 receive the byte at P+2.
- R5: When `done` is high, DR holds the byte at address TR and AR equals TR.
- R6: `done` is high for exactly one cycle. It goes high on the 12th rising edge, counting the edge that samples `start` as the first.
- R7: After a fetch the program counter equals P+3 modulo 65536, so it wraps from 0xFFFF to 0x0000. It changes only by single increments.
- R8: `start` is ignored while a fetch is in progress (timing state not T0). Such a pulse neither shortens, restarts nor repeats the fetch.
- R9: Read data is captured one cycle after `mem_rd`. The timing state holds through the wait cycle, and `mem_rd` is never high on two consecutive cycles.
- R10: If `start` is high in the cycle where `done` is high, the next fetch begins at the following edge, and back-to-back fetches take 12 cycles each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one instruction fetch; sampled in T0 |
| mem_rd | output | 1 | Memory read strobe, one cycle per read |
| mem_addr | output | AW | Read address (always the address register) |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | One-cycle pulse: operand is in DR |
| obs_tstate | output | 3 | Current timing state T0..T7 |
| obs_pc | output | AW | Program counter |
| obs_ar | output | AW | Address register |
| obs_tr | output | AW | Temporary register |
| obs_ir | output | DW | Instruction register |
| obs_dr | output | DW | Data register |

## Verification
Any corruption of the timing state or the wait phase shows up within one fetch. The read count or the read addresses come out wrong, or `done` moves away from its 12-cycle position. A byte latched into the wrong half of TR shows up twice: in `obs_tr` at the third read, and as a wrong fourth read address one state later. A missed or doubled increment changes the next fetch's first address and the program counter seen at `done`. The wrap case needs a reset value near the top of memory, because at three bytes per fetch the counter takes too long to reach 0xFFFF.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  typedef enum logic [2:0] {
    T0 = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3,
    T4 = 3'd4, T5 = 3'd5, T6 = 3'd6, T7 = 3'd7
  } tstate_e;

  typedef struct packed {
    logic ar_from_pc;
    logic ar_from_tr;
    logic rd_issue;
    logic ld_ir;
    logic ld_tr_hi;
    logic ld_tr_lo;
    logic ld_dr;
    logic pc_inc;
  } uop_t;

endpackage

// File: rtl/opfetch_timer.sv
module opfetch_timer
  import opfetch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output tstate_e tstate,
  output logic    pend,
  output uop_t    uop,
  output logic    done
);

  tstate_e t_q;
  logic    pend_q;
  logic    done_q;
  logic    is_rd;
  logic    cap;

  function automatic logic read_state(input tstate_e s);
    return s[0];
  endfunction

  function automatic tstate_e step(input tstate_e s);
    return tstate_e'(s + 3'd1);
  endfunction

  assign is_rd = read_state(t_q);
  assign cap   = is_rd && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q    <= T0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= cap && (t_q == T7);
      if (t_q == T0) begin
        if (start) t_q <= T1;
      end else if (is_rd) begin
        if (!pend_q) begin
          pend_q <= 1'b1;
        end else begin
          pend_q <= 1'b0;
          t_q    <= step(t_q);
        end
      end else begin
        t_q <= step(t_q);
      end
    end
  end

  always_comb begin
    uop            = '0;
    uop.ar_from_pc = ((t_q == T0) && start) || (t_q == T2) || (t_q == T4);
    uop.ar_from_tr = (t_q == T6);
    uop.rd_issue   = is_rd && !pend_q;
    uop.ld_ir      = cap && (t_q == T1);
    uop.ld_tr_hi   = cap && (t_q == T3);
    uop.ld_tr_lo   = cap && (t_q == T5);
    uop.ld_dr      = cap && (t_q == T7);
    uop.pc_inc     = cap && (t_q != T7);
  end

  assign tstate = t_q;
  assign pend   = pend_q;
  assign done   = done_q;

endmodule

// File: rtl/opfetch_addr_regs.sv
module opfetch_addr_regs
  import opfetch_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  uop_t          uop,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ar,
  output logic [AW-1:0] tr
);

  localparam int HALF = AW / 2;

  logic [AW-1:0] pc_q, ar_q, tr_q;

  function automatic logic [AW-1:0] pc_step(input logic [AW-1:0] v);
    return v + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [AW-1:0] put_hi(input logic [AW-1:0] v,
                                           input logic [DW-1:0] b);
    return {b[HALF-1:0], v[HALF-1:0]};
  endfunction

  function automatic logic [AW-1:0] put_lo(input logic [AW-1:0] v,
                                           input logic [DW-1:0] b);
    return {v[AW-1:HALF], b[HALF-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_PC;
      ar_q <= '0;
      tr_q <= '0;
    end else begin
      if (uop.pc_inc) pc_q <= pc_step(pc_q);
      if (uop.ar_from_pc)      ar_q <= pc_q;
      else if (uop.ar_from_tr) ar_q <= tr_q;
      if (uop.ld_tr_hi)      tr_q <= put_hi(tr_q, rdata);
      else if (uop.ld_tr_lo) tr_q <= put_lo(tr_q, rdata);
    end
  end

  assign pc = pc_q;
  assign ar = ar_q;
  assign tr = tr_q;

endmodule

// File: rtl/opfetch_data_regs.sv
module opfetch_data_regs
  import opfetch_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  uop_t          uop,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] dr
);

  logic [DW-1:0] ir_q, dr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      dr_q <= '0;
    end else begin
      if (uop.ld_ir) ir_q <= rdata;
      if (uop.ld_dr) dr_q <= rdata;
    end
  end

  assign ir = ir_q;
  assign dr = dr_q;

endmodule

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
  import opfetch_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [2:0]    obs_tstate,
  output logic [AW-1:0] obs_pc,
  output logic [AW-1:0] obs_ar,
  output logic [AW-1:0] obs_tr,
  output logic [DW-1:0] obs_ir,
  output logic [DW-1:0] obs_dr
);

  tstate_e       tstate;
  logic          pend;
  uop_t          uop;
  logic [AW-1:0] pc, ar, tr;

  // named internal events
  logic ev_rd_issue;
  logic ev_capture;
  logic ev_pc_inc;

  opfetch_timer u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .tstate (tstate),
    .pend   (pend),
    .uop    (uop),
    .done   (done)
  );

  opfetch_addr_regs #(.AW(AW), .DW(DW), .RESET_PC(RESET_PC)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .uop   (uop),
    .rdata (mem_rdata),
    .pc    (pc),
    .ar    (ar),
    .tr    (tr)
  );

  opfetch_data_regs #(.DW(DW)) u_data (
    .clk   (clk),
    .rst   (rst),
    .uop   (uop),
    .rdata (mem_rdata),
    .ir    (obs_ir),
    .dr    (obs_dr)
  );

  assign ev_rd_issue = uop.rd_issue;
  assign ev_capture  = uop.ld_ir | uop.ld_tr_hi | uop.ld_tr_lo | uop.ld_dr;
  assign ev_pc_inc   = uop.pc_inc;

  assign mem_rd     = ev_rd_issue;
  assign mem_addr   = ar;
  assign obs_tstate = tstate;
  assign obs_pc     = pc;
  assign obs_ar     = ar;
  assign obs_tr     = tr;

endmodule

// File: rtl/opfetch_ctrl_chk.sv
module opfetch_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic [2:0]    obs_tstate,
  input logic [AW-1:0] obs_pc,
  input logic [AW-1:0] obs_tr,
  input logic [AW-1:0] obs_ar
);

  // R9
  rd_no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R9
  rd_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (obs_tstate == $past(obs_tstate)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_ar_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (obs_ar == obs_tr) && (obs_tstate == 3'd0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (obs_tstate == 3'd0 && !start) |=> (obs_tstate == 3'd0) && !mem_rd);

  // R3
  opcode_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && obs_tstate == 3'd1) |-> (mem_addr == obs_pc));

  // R3
  operand_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && obs_tstate == 3'd7) |-> (mem_addr == obs_tr));

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && obs_pc != $past(obs_pc)) |-> (obs_pc == $past(obs_pc) + 1'b1));

endmodule

bind opfetch_ctrl opfetch_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .mem_rd     (mem_rd),
  .mem_addr   (mem_addr),
  .done       (done),
  .obs_tstate (obs_tstate),
  .obs_pc     (obs_pc),
  .obs_tr     (obs_tr),
  .obs_ar     (obs_ar)
);

// File: tb/opfetch_ctrl_bench.sv
module opfetch_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  // vector: gap[11:8], start poke cycle[7:4] (0 = none), expected cycles[3:0]
  localparam logic [11:0] VEC [6] = '{
    12'h00C, 12'h35C, 12'h1AC, 12'h27C, 12'h0BC, 12'h52C
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [2:0]  obs_tstate;
  logic [15:0] obs_pc, obs_ar, obs_tr;
  logic [7:0]  obs_ir, obs_dr;

  logic        start_w = 1'b0;
  logic        mem_rd_w;
  logic [15:0] mem_addr_w;
  logic [7:0]  mem_rdata_w = '0;
  logic        done_w;
  logic [2:0]  tstate_w;
  logic [15:0] pc_w, ar_w, tr_w;
  logic [7:0]  ir_w, dr_w;

  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;
  logic [15:0] mpc = 16'h0000;
  logic [15:0] rlog [4];
  int          rlog_n = 0;
  int          rd_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opfetch_ctrl u_opfetch_ctrl (
    .clk(clk), .rst(rst), .start(start), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .obs_tstate(obs_tstate), .obs_pc(obs_pc),
    .obs_ar(obs_ar), .obs_tr(obs_tr), .obs_ir(obs_ir), .obs_dr(obs_dr)
  );

  opfetch_ctrl #(.RESET_PC(16'hFFFE)) u_opfetch_ctrl_wrap (
    .clk(clk), .rst(rst), .start(start_w), .mem_rd(mem_rd_w), .mem_addr(mem_addr_w),
    .mem_rdata(mem_rdata_w), .done(done_w), .obs_tstate(tstate_w), .obs_pc(pc_w),
    .obs_ar(ar_w), .obs_tr(tr_w), .obs_ir(ir_w), .obs_dr(dr_w)
  );

  // memory contents computed from the address
  function automatic logic [7:0] hb(input logic [15:0] a);
    logic [7:0] x;
    x = (a[7:0] * 8'd113) ^ (a[15:8] * 8'd29) ^ 8'h3C;
    return x;
  endfunction

  always @(posedge clk) begin
    if (mem_rd)   mem_rdata   <= hb(mem_addr);
    if (mem_rd_w) mem_rdata_w <= hb(mem_addr_w);
  end

  always @(negedge clk) begin
    if (mem_rd) begin
      rd_total = rd_total + 1;
      if (rlog_n < 4) rlog[rlog_n] = mem_addr;
      rlog_n = rlog_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic run_fetch(input int gap, input int poke, input int expcyc);
    logic [15:0] pc0, tr_e;
    int cyc;
    bit got;
    repeat (gap) @(negedge clk);
    pc0 = mpc;
    rlog_n = 0;
    start = 1'b1;
    cyc = 0;
    got = 1'b0;
    while (!got && cyc < 40) begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke);
      if (done) got = 1'b1;
    end
    start = 1'b0;
    tr_e = {hb(pc0 + 16'd1), hb(pc0 + 16'd2)};
    chk("R6 done cycle", cyc, expcyc);
    chk("R8 poke ignored cycle count", cyc, 12);
    chk("R4 IR", obs_ir, hb(pc0));
    chk("R4 TR", obs_tr, tr_e);
    chk("R5 DR", obs_dr, hb(tr_e));
    chk("R5 AR", obs_ar, tr_e);
    chk("R7 PC", obs_pc, pc0 + 16'd3);
    chk("R3 read count", rlog_n, 4);
    chk("R3 addr0", rlog[0], pc0);
    chk("R3 addr1", rlog[1], pc0 + 16'd1);
    chk("R3 addr2", rlog[2], pc0 + 16'd2);
    chk("R3 addr3", rlog[3], tr_e);
    @(negedge clk);
    chk("R6 done single", done, 0);
    chk("R8 back to T0", obs_tstate, 0);
    mpc = pc0 + 16'd3;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [15:0] pc0, tr_e;
    int cyc, d1, d2, nd, rd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tstate", obs_tstate, 0);
    chk("R1 pc", obs_pc, 16'h0000);
    chk("R1 ar/tr", {obs_ar, obs_tr}, 0);
    chk("R1 ir/dr", {obs_ir, obs_dr}, 0);
    chk("R1 done/rd", {done, mem_rd}, 0);
    chk("R1 pc reset param", pc_w, 16'hFFFE);
    rst = 1'b0;
    @(negedge clk);

    foreach (VEC[i]) run_fetch(int'(VEC[i][11:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]));

    // R2 idle: no reads, no register changes
    rd0 = rd_total;
    pc0 = obs_pc;
    tr_e = obs_tr;
    repeat (8) @(negedge clk);
    chk("R2 no reads", rd_total - rd0, 0);
    chk("R2 pc hold", obs_pc, pc0);
    chk("R2 tr hold", obs_tr, tr_e);
    chk("R2 tstate", obs_tstate, 0);

    // R10 back-to-back with start held
    pc0 = mpc;
    start = 1'b1;
    cyc = 0; nd = 0; d1 = 0; d2 = 0;
    while (nd < 2 && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (cyc == 13) start = 1'b0;
      if (done) begin
        nd++;
        if (nd == 1) d1 = cyc; else d2 = cyc;
      end
    end
    start = 1'b0;
    tr_e = {hb(pc0 + 16'd4), hb(pc0 + 16'd5)};
    chk("R10 first done", d1, 12);
    chk("R10 second done", d2, 24);
    chk("R10 pc", obs_pc, pc0 + 16'd6);
    chk("R10 DR", obs_dr, hb(tr_e));
    mpc = pc0 + 16'd6;

    // R1 reset in mid-fetch
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset tstate", obs_tstate, 0);
    chk("R1 mid reset pc", obs_pc, 16'h0000);
    chk("R1 mid reset regs", {obs_ar, obs_tr, obs_ir, obs_dr}, 0);
    chk("R1 mid reset rd", mem_rd, 0);
    mpc = 16'h0000;
    run_fetch(1, 0, 12);

    // R7 wrap from 0xFFFE
    start_w = 1'b1;
    cyc = 0;
    while (!done_w && cyc < 40) begin
      @(negedge clk);
      cyc++;
      start_w = 1'b0;
    end
    tr_e = {hb(16'hFFFF), hb(16'h0000)};
    chk("R7 wrap cycles", cyc, 12);
    chk("R7 wrap IR", ir_w, hb(16'hFFFE));
    chk("R7 wrap TR", tr_w, tr_e);
    chk("R7 wrap DR", dr_w, hb(tr_e));
    chk("R7 wrap PC", pc_w, 16'h0001);

    summary();
  end

endmodule